// File: doc/BRIEF.md
# Setting-code serial target with destination routing

This block is a two-wire serial (I2C) target for one fixed 7-bit address. A write carries one data byte: seven bits of setting code and one bit that chooses where the code goes. It either goes into the live setting register, whose value is on the `live_code` output, or to a separate nonvolatile store controller. A read returns the live setting. The block runs from a fast system clock and oversamples both bus lines. Each line passes through a two-flop synchronizer and a counting glitch filter. SDA is driven only as an open-drain pull-down enable.

The store controller is reached through a single-cycle request. When the data byte is complete and its destination bit is 0, the block raises `st_req` for one cycle with the code on `st_code`. In that same cycle `st_accept` reports whether the store takes the code. The target then ACKs or NACKs the data byte to match. Transfers longer than one data byte, clock stretching and general call are not handled.

Top module: `vset_i2c_target`

## Requirements
- R1: The address byte 0x9E (write) or 0x9F (read), target address 7'h4F in bits 7..1 and the R/W bit in bit 0, is ACKed. Any other address byte is NACKed, and the target then drives nothing and writes nothing until the next START or STOP.
- R2: A data byte whose bit 0 is 1 loads its bits 7..1 into `live_code` and is ACKed. The new value appears at the SCL fall that opens the ACK clock, before the STOP.
- R3: A data byte whose bit 0 is 0 raises `st_req` for exactly one cycle, with `st_code` equal to the byte's bits 7..1, and leaves `live_code` unchanged.
- R4: For a store-destination byte, the data byte is ACKed when `st_accept` is 1 in the `st_req` cycle and NACKed when it is 0.
- R5: An ACK holds `sda_oe` at 1 for the whole high period of the ninth SCL clock and releases it after that clock falls.
- R6: A read returns `live_code` MSB first in bits 7..1, with bit 0 sent as a released (1) bit.
- R7: A STOP at any point in the data byte ends the transfer without a store request and without changing `live_code`. The next transfer works normally.
- R8: A STOP that falls in the same SCL high period as the START is not recognised, and the transfer that follows proceeds.
- R9: An SCL pulse shorter than FILT_CYCLES system clocks is discarded and does not count as a bit clock.
- R10: After reset, `live_code` is INIT_CODE (7'h40), and `sda_oe` and `st_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| live_code | output | 7 | Live setting register |
| st_req | output | 1 | One-cycle request to write the store |
| st_code | output | 7 | Code offered to the store with `st_req` |
| st_accept | input | 1 | Store takes the code; sampled with `st_req` |

## Verification
The bench targets the cases where the ACK decision depends on late information. A rejected store write must come back as a NACK; a design that ACKs every matched byte would hide a full or busy store. A START followed by a STOP in the same SCL high period is sent on purpose; a design that honours that STOP returns to idle and NACKs the address. A STOP cut into the middle of a data byte must not leave a partial code in `live_code`. A short SCL spike is injected in the middle of a byte; if it got through, every later bit would shift by one and the wrong code would be stored.

// File: rtl/vset_pkg.sv
package vset_pkg;
  localparam int BYTE_W = 8;
  localparam int CODE_W = BYTE_W - 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WDATA, ST_WACK, ST_RDATA, ST_RACK, ST_SKIP
  } tgt_state_e;

  // Address byte hits when its upper seven bits equal the target address.
  function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                    input logic [CODE_W-1:0] tgt);
    return b[BYTE_W-1:1] == tgt;
  endfunction

  // Payload of a data byte: bits 7..1.
  function automatic logic [CODE_W-1:0] payload(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1:1];
  endfunction
endpackage

// File: rtl/vset_line_filter.sv
module vset_line_filter #(
  parameter int FILT_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);
  localparam int CW = $clog2(FILT_CYCLES + 1);

  logic s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= 1'b1;
      s2   <= 1'b1;
      filt <= 1'b1;
      cnt  <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
      if (s2 != filt) begin
        if (cnt == CW'(FILT_CYCLES - 1)) begin
          filt <= s2;
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/vset_bus_events.sv
module vset_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q, start_hi;

  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  assign start_ev = scl_f & scl_q & sda_q & ~sda_f;
  // A STOP inside the same SCL high period as a START is not honoured.
  assign stop_ev  = scl_f & scl_q & ~sda_q & sda_f & ~start_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      start_hi <= 1'b0;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
      if (start_ev)      start_hi <= 1'b1;
      else if (scl_fall) start_hi <= 1'b0;
    end
  end
endmodule

// File: rtl/vset_target_fsm.sv
module vset_target_fsm
  import vset_pkg::*;
#(
  parameter logic [CODE_W-1:0] TGT_ADDR  = 7'h4F,
  parameter logic [CODE_W-1:0] INIT_CODE = 7'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_f,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              st_accept,
  output logic              sda_oe,
  output logic [CODE_W-1:0] live_code,
  output logic              st_req,
  output logic [CODE_W-1:0] st_code,
  output logic              in_skip
);
  tgt_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sr;
  logic              rw;
  logic              byte_full;

  assign byte_full = (cnt == CNT_W'(BYTE_W));
  assign st_code   = payload(sr);
  assign st_req    = (state == ST_WDATA) && byte_full && scl_fall && !sr[0];
  assign in_skip   = (state == ST_SKIP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      sr        <= '0;
      rw        <= 1'b0;
      sda_oe    <= 1'b0;
      live_code <= INIT_CODE;
    end else if (start_ev) begin
      state  <= ST_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_ev) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (scl_rise) begin
      if ((state == ST_ADDR || state == ST_WDATA) && !byte_full) begin
        sr  <= {sr[BYTE_W-2:0], sda_f};
        cnt <= cnt + 1'b1;
      end
    end else if (scl_fall) begin
      case (state)
        ST_ADDR: if (byte_full) begin
          if (addr_hit(sr, TGT_ADDR)) begin
            state  <= ST_AACK;
            sda_oe <= 1'b1;
            rw     <= sr[0];
          end else begin
            state  <= ST_SKIP;
            sda_oe <= 1'b0;
          end
        end
        ST_AACK: begin
          cnt <= '0;
          if (rw) begin
            sr     <= {live_code, 1'b1};
            sda_oe <= ~live_code[CODE_W-1];
            state  <= ST_RDATA;
          end else begin
            sda_oe <= 1'b0;
            state  <= ST_WDATA;
          end
        end
        ST_WDATA: if (byte_full) begin
          state <= ST_WACK;
          if (sr[0]) begin
            live_code <= payload(sr);
            sda_oe    <= 1'b1;
          end else begin
            sda_oe <= st_accept;
          end
        end
        ST_WACK: begin
          sda_oe <= 1'b0;
          state  <= ST_SKIP;
        end
        ST_RDATA: begin
          if (cnt == CNT_W'(BYTE_W - 1)) begin
            sda_oe <= 1'b0;
            state  <= ST_RACK;
          end else begin
            sr     <= sr << 1;
            sda_oe <= ~sr[BYTE_W-2];
            cnt    <= cnt + 1'b1;
          end
        end
        ST_RACK: state <= ST_SKIP;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vset_i2c_target.sv
module vset_i2c_target
  import vset_pkg::*;
#(
  parameter logic [CODE_W-1:0] TGT_ADDR    = 7'h4F,
  parameter logic [CODE_W-1:0] INIT_CODE   = 7'h40,
  parameter int                FILT_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [CODE_W-1:0] live_code,
  output logic              st_req,
  output logic [CODE_W-1:0] st_code,
  input  logic              st_accept
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw_lines, filt_lines;
  logic scl_f, sda_f, scl_rise, scl_fall, start_ev, stop_ev, in_skip;

  assign raw_lines = {sda_i, scl_i};
  assign scl_f     = filt_lines[0];
  assign sda_f     = filt_lines[1];

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    vset_line_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (raw_lines[g]),
      .filt (filt_lines[g])
    );
  end

  vset_bus_events u_events (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_f   (scl_f),
    .sda_f   (sda_f),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_ev(start_ev),
    .stop_ev (stop_ev)
  );

  vset_target_fsm #(.TGT_ADDR(TGT_ADDR), .INIT_CODE(INIT_CODE)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_f    (sda_f),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .st_accept(st_accept),
    .sda_oe   (sda_oe),
    .live_code(live_code),
    .st_req   (st_req),
    .st_code  (st_code),
    .in_skip  (in_skip)
  );
endmodule

// File: rtl/vset_i2c_target_chk.sv
module vset_i2c_target_chk #(
  parameter int CODE_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_f,
  input logic              scl_fall,
  input logic              sda_oe,
  input logic              st_req,
  input logic              in_skip,
  input logic [CODE_W-1:0] live_code
);
  AST_OE_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_f && $past(scl_f)) |-> $stable(sda_oe)); // R5
  AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    st_req |=> !st_req); // R3
  AST_REQ_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    st_req |-> !scl_f); // R3
  AST_LIVE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(live_code) |-> $past(scl_fall)); // R2
  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_skip |-> !sda_oe); // R1
endmodule

bind vset_i2c_target vset_i2c_target_chk #(.CODE_W(vset_pkg::CODE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_f    (scl_f),
  .scl_fall (scl_fall),
  .sda_oe   (sda_oe),
  .st_req   (st_req),
  .in_skip  (in_skip),
  .live_code(live_code)
);

// File: tb/vset_i2c_target_tb.sv
module vset_i2c_target_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_drv = 1'b1, sda_drv = 1'b1;
  logic st_accept = 1'b1;
  logic sda_oe, st_req;
  logic [6:0] live_code, st_code;
  wire  sda_line = sda_drv & ~sda_oe;

  int checks = 0, fails = 0, req_n = 0;
  logic [6:0] req_code = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vset_i2c_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
    .sda_oe(sda_oe), .live_code(live_code), .st_req(st_req),
    .st_code(st_code), .st_accept(st_accept)
  );

  always @(posedge clk) if (st_req) begin req_n++; req_code = st_code; end

  task automatic wq(input int n); repeat (n) @(negedge clk); endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start; sda_drv = 1; scl_drv = 1; wq(Q); sda_drv = 0; wq(Q); scl_drv = 0; wq(Q); endtask
  task automatic bus_stop;  sda_drv = 0; wq(Q); scl_drv = 1; wq(Q); sda_drv = 1; wq(Q); endtask

  task automatic send_bit(input bit b, input bit glitch);
    sda_drv = b;
    if (glitch) begin
      wq(5); scl_drv = 1; wq(2); scl_drv = 0; wq(Q - 7);
    end else wq(Q);
    scl_drv = 1; wq(2 * Q); scl_drv = 0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch,
                           output bit acked, output bit held);
    bit s1, s2;
    for (int i = 7; i >= 0; i--) send_bit(b[i], glitch && i == 3);
    sda_drv = 1; wq(Q); scl_drv = 1; wq(2);
    s1 = sda_oe; acked = !sda_line;
    wq(2 * Q - 4); s2 = sda_oe; wq(2); scl_drv = 0; wq(Q);
    held = s1 && s2 && !sda_oe;
  endtask

  task automatic recv_byte(output logic [7:0] d, input bit mack);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = 1; wq(Q); scl_drv = 1; wq(Q); d[i] = sda_line; wq(Q); scl_drv = 0; wq(Q);
    end
    sda_drv = ~mack; wq(Q); scl_drv = 1; wq(2 * Q); scl_drv = 0; wq(Q);
  endtask

  task automatic t_reset;
    check(live_code == 7'h40, "R10 live_code", live_code, 7'h40);
    check(sda_oe == 0, "R10 sda_oe", sda_oe, 0);
    check(req_n == 0, "R10 st_req", req_n, 0);
  endtask

  task automatic t_live_write(input logic [6:0] code);
    bit a, d, h, h2;
    bus_start;
    send_byte(8'h9E, 0, a, h);
    check(a, "R1 write address ACK", a, 1);
    send_byte({code, 1'b1}, 0, d, h2);
    check(d, "R2 data ACK", d, 1);
    check(h2, "R5 ACK held over ninth clock", h2, 1);
    check(live_code == code, "R2 live before STOP", live_code, code);
    bus_stop;
  endtask

  task automatic t_read(input logic [6:0] exp);
    bit a, h; logic [7:0] d;
    bus_start;
    send_byte(8'h9F, 0, a, h);
    check(a, "R1 read address ACK", a, 1);
    recv_byte(d, 0);
    check(d[7:1] == exp, "R6 read code", d[7:1], exp);
    check(d[0] == 1, "R6 read bit0 released", d[0], 1);
    bus_stop;
  endtask

  task automatic t_store(input logic [6:0] code, input bit acc);
    bit a, d, h; int n0; logic [6:0] l0;
    n0 = req_n; l0 = live_code; st_accept = acc;
    bus_start;
    send_byte(8'h9E, 0, a, h);
    send_byte({code, 1'b0}, 0, d, h);
    bus_stop;
    check(req_n == n0 + 1, "R3 one store request", req_n - n0, 1);
    check(req_code == code, "R3 store code", req_code, code);
    check(live_code == l0, "R3 live unchanged", live_code, l0);
    check(d == acc, "R4 ACK follows accept", d, acc);
    st_accept = 1;
  endtask

  task automatic t_mismatch;
    bit a, d, h; int n0; logic [6:0] l0;
    n0 = req_n; l0 = live_code;
    bus_start;
    send_byte(8'h9C, 0, a, h);
    check(!a, "R1 foreign address NACK", a, 0);
    send_byte({7'h11, 1'b1}, 0, d, h);
    check(!d, "R1 data ignored after NACK", d, 0);
    send_byte({7'h12, 1'b0}, 0, d, h);
    bus_stop;
    check(live_code == l0, "R1 live untouched", live_code, l0);
    check(req_n == n0, "R1 no store request", req_n - n0, 0);
  endtask

  task automatic t_stop_abort;
    bit a, h; int n0; logic [6:0] l0;
    n0 = req_n; l0 = live_code;
    bus_start;
    send_byte(8'h9E, 0, a, h);
    send_bit(0, 0); send_bit(1, 0); send_bit(1, 0); send_bit(0, 0);
    bus_stop;
    check(live_code == l0, "R7 live after early STOP", live_code, l0);
    check(req_n == n0, "R7 no request after early STOP", req_n - n0, 0);
    t_live_write(7'h33);
    check(live_code == 7'h33, "R7 recovery write", live_code, 7'h33);
  endtask

  task automatic t_start_stop_same_high;
    bit a, d, h;
    sda_drv = 1; scl_drv = 1; wq(Q);
    sda_drv = 0; wq(Q);
    sda_drv = 1; wq(Q);
    scl_drv = 0; wq(Q);
    send_byte(8'h9E, 0, a, h);
    check(a, "R8 address ACK after START+STOP in one high", a, 1);
    send_byte({7'h07, 1'b1}, 0, d, h);
    bus_stop;
    check(live_code == 7'h07, "R8 write completes", live_code, 7'h07);
  endtask

  task automatic t_glitch;
    bit a, d, h;
    bus_start;
    send_byte(8'h9E, 0, a, h);
    send_byte({7'h5A, 1'b1}, 1, d, h);
    bus_stop;
    check(d, "R9 ACK despite SCL spike", d, 1);
    check(live_code == 7'h5A, "R9 code not shifted", live_code, 7'h5A);
  endtask

  initial begin
    wq(10); rst_n = 1; wq(10);
    t_reset;
    t_live_write(7'h2A);
    t_read(7'h2A);
    t_store(7'h15, 1);
    t_store(7'h16, 0);
    t_mismatch;
    t_stop_abort;
    t_start_stop_same_high;
    t_glitch;
    t_read(7'h5A);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule